// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Register Bank

This block is a down-counting watchdog for a peripheral bus. Software programs a reload value and must service the timer before it runs out. The first time the count runs out, the block raises an interrupt. If software has still not cleared that interrupt when the count runs out a second time, the block raises a reset request and freezes the counter. Both outputs can be gated by enable bits.

A lock register guards every other register against stray writes and opens only when it receives a fixed key. An integration-test mode lets board tests drive the two outputs directly from a register. A bank of fixed identification bytes is readable at the top of the address window.

The counter moves only on a single-cycle tick-enable input that shares the bus clock. A slower count rate is produced outside the block by pulsing that input less often.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the interrupt and reset outputs are low. The reload value (0x000) and the current count (0x004) both read 0xFFFFFFFF. Control (0x008), raw status (0x010), lock (0xC00) and integration control (0xF00) read 0. The counter is running.
- R2: A write to 0x000 sets the reload value, loads the counter with the written value in the same write, and restarts counting even if the counter had stopped.
- R3: While running, each tick-enable pulse lowers the count by one. Expiry is the tick that takes the count from 1 to 0. The tick after that reloads the count from the reload value instead of wrapping.
- R4: An expiry while the raw flag is clear sets the raw flag (raw status bit 0 at 0x010). An expiry while the raw flag is set sets the reset-status flag and stops the counter.
- R5: Any write to 0x00C clears the raw flag and reloads the count from the reload value. It does not clear the reset-status flag.
- R6: Only control bits 0 (interrupt enable) and 1 (reset enable) are stored; the other control bits read 0. The interrupt output is raw flag AND bit 0. The reset output is reset-status AND bit 1. Masked status at 0x014 reads raw flag AND bit 0.
- R7: Writing 0x1ACCE551 to 0xC00 unlocks the block and any other value locks it. The lock register reads 1 when locked and 0 when unlocked. While locked, all writes except those to 0xC00 are ignored.
- R8: When integration control bit 0 is set, the interrupt output follows bit 1 of the integration-output register (0xF04) and the reset output follows bit 0 of that register.
- R9: The twelve words at 0xFD0..0xFFC read, in address order, the bytes 04,00,00,00,24,B8,1B,00,0D,F0,05,B1.
- R10: Reads of the write-only offsets 0x00C and 0xF04, and of unmapped offsets, return 0. Writes to read-only or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable pulse, one decrement per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | AW (12) | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| wdog_irq | output | 1 | Interrupt request |
| wdog_reset | output | 1 | Reset request |

## Verification
A register write takes effect at the clock edge that completes its access phase. Its result is visible on prdata and on the two outputs from the next cycle onwards. A tick works the same way: the count, the flags and the outputs all change at the edge on which tick_en is high. Read data is combinational on the address, so it is valid during the access phase itself. The bench therefore drives every input on the falling edge and samples only on the falling edge after the rising edge that should have acted. A reference count, flag and stop model in the bench advances once per tick and is compared after each one.

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int          CW         = 32,
  parameter int          AW         = 12,
  parameter logic [31:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          wdog_irq,
  output logic          wdog_reset
);
  localparam logic [AW-1:0] A_LOAD  = AW'('h000);
  localparam logic [AW-1:0] A_VAL   = AW'('h004);
  localparam logic [AW-1:0] A_CTRL  = AW'('h008);
  localparam logic [AW-1:0] A_CLR   = AW'('h00C);
  localparam logic [AW-1:0] A_RAW   = AW'('h010);
  localparam logic [AW-1:0] A_MSK   = AW'('h014);
  localparam logic [AW-1:0] A_LOCK  = AW'('hC00);
  localparam logic [AW-1:0] A_ITEN  = AW'('hF00);
  localparam logic [AW-1:0] A_ITOUT = AW'('hF04);
  localparam logic [AW-1:0] A_ID0   = AW'('hFD0);
  localparam logic [AW-1:0] A_IDN   = AW'('hFFC);

  logic [CW-1:0] reload_q, count_q;
  logic          running_q, raw_q, rstf_q, locked_q, iten_q;
  logic [1:0]    ctrl_q, itout_q;

  wire wr      = psel & penable & pwrite;
  wire wr_ok   = wr & (~locked_q | (paddr == A_LOCK));
  wire wr_load = wr_ok & (paddr == A_LOAD);
  wire wr_clr  = wr_ok & (paddr == A_CLR);
  wire expire  = tick_en & running_q & (count_q == CW'(1)) & ~wr_load & ~wr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q  <= '1;
      count_q   <= '1;
      running_q <= 1'b1;
      raw_q     <= 1'b0;
      rstf_q    <= 1'b0;
    end else begin
      if (wr_load) begin
        reload_q  <= pwdata[CW-1:0];
        count_q   <= pwdata[CW-1:0];
        running_q <= 1'b1;
      end else if (wr_clr) begin
        count_q <= reload_q;
      end else if (tick_en && running_q) begin
        count_q <= (count_q == '0) ? reload_q : count_q - CW'(1);
      end
      if (wr_clr) raw_q <= 1'b0;
      else if (expire && !raw_q) raw_q <= 1'b1;
      if (expire && raw_q) begin
        rstf_q    <= 1'b1;
        running_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      locked_q <= 1'b0;
      iten_q   <= 1'b0;
      itout_q  <= '0;
    end else if (wr_ok) begin
      case (paddr)
        A_CTRL:  ctrl_q   <= pwdata[1:0];
        A_LOCK:  locked_q <= (pwdata != UNLOCK_KEY);
        A_ITEN:  iten_q   <= pwdata[0];
        A_ITOUT: itout_q  <= pwdata[1:0];
        default: ;
      endcase
    end
  end

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h24;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  wire [AW-1:0] id_off = paddr - A_ID0;

  always_comb begin
    prdata = '0;
    case (paddr)
      A_LOAD:  prdata = 32'(reload_q);
      A_VAL:   prdata = 32'(count_q);
      A_CTRL:  prdata = {30'd0, ctrl_q};
      A_RAW:   prdata = {31'd0, raw_q};
      A_MSK:   prdata = {31'd0, raw_q & ctrl_q[0]};
      A_LOCK:  prdata = {31'd0, locked_q};
      A_ITEN:  prdata = {31'd0, iten_q};
      default:
        if (paddr >= A_ID0 && paddr <= A_IDN && paddr[1:0] == 2'b00)
          prdata = {24'd0, id_byte(id_off[5:2])};
    endcase
  end

  assign wdog_irq   = iten_q ? itout_q[1] : (raw_q & ctrl_q[0]);
  assign wdog_reset = iten_q ? itout_q[0] : (rstf_q & ctrl_q[1]);

  a_r2_load_sets_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (count_q == $past(pwdata[CW-1:0])) && running_q);
  a_r3_expire_hits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count_q == '0);
  a_r4_reset_after_raw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstf_q) |-> $past(raw_q));
  a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !wr) |=> $stable(count_q));
  a_r7_locked_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked_q && paddr != A_LOCK) |=> $stable(ctrl_q) && $stable(reload_q) && $stable(iten_q));
  a_r5_clear_drops_raw: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> !raw_q);
endmodule

// File: tb/sim_wdog_twostage.sv
module sim_wdog_twostage;
  logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        wdog_irq, wdog_reset;
  int          n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  wdog_twostage u0 (.clk, .rst_n, .tick_en, .psel, .penable, .pwrite,
                    .paddr, .pwdata, .prdata, .wdog_irq, .wdog_reset);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hard_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk) begin psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d; end
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk) begin psel = 1; pwrite = 0; penable = 0; paddr = a; end
    @(negedge clk) penable = 1;
    #1 d = prdata;
    @(negedge clk) begin psel = 0; penable = 0; end
  endtask

  task automatic tick();
    @(negedge clk) tick_en = 1;
    @(negedge clk) tick_en = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  idb [12] = '{8'h04,8'h00,8'h00,8'h00,8'h24,8'hB8,8'h1B,8'h00,8'h0D,8'hF0,8'h05,8'hB1};

    // R1 reset state
    hard_reset();
    chk("R1 irq", {31'd0, wdog_irq}, 0);
    chk("R1 rst", {31'd0, wdog_reset}, 0);
    rd(12'h000, d); chk("R1 load", d, 32'hFFFFFFFF);
    rd(12'h004, d); chk("R1 value", d, 32'hFFFFFFFF);
    rd(12'h008, d); chk("R1 ctrl", d, 0);
    rd(12'h010, d); chk("R1 raw", d, 0);
    rd(12'hC00, d); chk("R1 lock", d, 0);
    rd(12'hF00, d); chk("R1 itcr", d, 0);
    for (int i = 0; i < 3; i++) tick();
    rd(12'h004, d); chk("R1 R3 running after reset", d, 32'hFFFFFFFC);

    // R3 R4 R6 sweep over reload values and enable combinations
    for (int L = 1; L <= 5; L++) begin
      for (int en = 0; en < 4; en++) begin
        int m; bit raw, rf, run;
        hard_reset();
        wr(12'h008, en);
        wr(12'h000, L);
        m = L; raw = 0; rf = 0; run = 1;
        for (int k = 0; k < 2*L + 3; k++) begin
          tick();
          if (run) begin
            if (m == 0) m = L;
            else if (m == 1) begin
              m = 0;
              if (!raw) raw = 1; else begin rf = 1; run = 0; end
            end else m--;
          end
          chk("R3 count", {31'd0, wdog_irq}, {31'd0, raw & en[0]});
          chk("R4 R6 reset out", {31'd0, wdog_reset}, {31'd0, rf & en[1]});
          rd(12'h004, d); chk("R3 R4 value", d, m);
        end
        rd(12'h014, d); chk("R6 masked", d, {31'd0, raw & en[0]});
      end
    end

    // R6 R2 R5 R10 directed
    hard_reset();
    wr(12'h008, 32'hFFFFFFFF);
    rd(12'h008, d); chk("R6 ctrl bits", d, 3);
    wr(12'h000, 2);
    rd(12'h004, d); chk("R2 load value", d, 2);
    tick(); tick();
    rd(12'h010, d); chk("R4 raw set", d, 1);
    rd(12'h014, d); chk("R6 masked set", d, 1);
    chk("R6 irq", {31'd0, wdog_irq}, 1);
    wr(12'h008, 2);
    chk("R6 irq gated", {31'd0, wdog_irq}, 0);
    rd(12'h014, d); chk("R6 masked gated", d, 0);
    rd(12'h010, d); chk("R6 raw kept", d, 1);
    wr(12'h00C, 32'h0);
    rd(12'h010, d); chk("R5 raw cleared", d, 0);
    rd(12'h004, d); chk("R5 reloaded", d, 2);
    wr(12'h004, 7);
    rd(12'h004, d); chk("R10 value read-only", d, 2);
    wr(12'h014, 1);
    rd(12'h014, d); chk("R10 masked read-only", d, 0);

    // R7 lock
    wr(12'hC00, 5);
    rd(12'hC00, d); chk("R7 locked", d, 1);
    wr(12'h000, 9);
    rd(12'h000, d); chk("R7 load ignored", d, 2);
    wr(12'h008, 0);
    rd(12'h008, d); chk("R7 ctrl ignored", d, 2);
    wr(12'hF00, 1);
    rd(12'hF00, d); chk("R7 itcr ignored", d, 0);
    wr(12'hC00, 32'h1ACCE551);
    rd(12'hC00, d); chk("R7 unlocked", d, 0);
    wr(12'h000, 9);
    rd(12'h000, d); chk("R7 load after unlock", d, 9);

    // R8 integration override
    wr(12'hF00, 1);
    rd(12'hF00, d); chk("R8 itcr", d, 1);
    for (int v = 0; v < 4; v++) begin
      wr(12'hF04, v);
      chk("R8 irq", {31'd0, wdog_irq}, (v >> 1) & 1);
      chk("R8 rst", {31'd0, wdog_reset}, v & 1);
    end
    wr(12'hF00, 0);
    chk("R8 irq normal", {31'd0, wdog_irq}, 0);
    chk("R8 rst normal", {31'd0, wdog_reset}, 0);

    // R9 ID bytes
    for (int i = 0; i < 12; i++) begin
      rd(12'hFD0 + 12'(4*i), d); chk("R9 id", d, {24'd0, idb[i]});
    end

    // R10 write-only and unmapped reads
    rd(12'h00C, d); chk("R10 clr reads 0", d, 0);
    rd(12'hF04, d); chk("R10 itop reads 0", d, 0);
    rd(12'h018, d); chk("R10 hole 018", d, 0);
    rd(12'h800, d); chk("R10 hole 800", d, 0);
    rd(12'hFCC, d); chk("R10 hole FCC", d, 0);

    // R5 R4 reset flag survives clear, counter stays stopped
    hard_reset();
    wr(12'h008, 3);
    wr(12'h000, 1);
    tick(); tick(); tick();
    chk("R4 reset out", {31'd0, wdog_reset}, 1);
    wr(12'h00C, 0);
    rd(12'h010, d); chk("R5 raw cleared late", d, 0);
    chk("R5 reset kept", {31'd0, wdog_reset}, 1);
    tick(); tick();
    rd(12'h004, d); chk("R4 stopped", d, 1);
    wr(12'h000, 3);
    tick();
    rd(12'h004, d); chk("R2 restart", d, 2);

    summary();
  end
endmodule